// File: doc/BRIEF.md
# Auxiliary I/O and System-Control Register Block

This block is a small set of memory-mapped control registers for a workstation's auxiliary I/O and system control. It holds a byte-wide configuration register, a diagnostic byte, a modem-control byte, a misc-functions byte (aux1), a power-control byte (aux2), a 16-bit LED register and a system-control register that is accessed as a 32-bit word. Each register region has its own select line on a simple register bus. A write strobe, an access size, a byte offset and write data are shared by all regions. Read data is combinational from the selected region.

A power-failing input from the supply passes through a synchronizer. It sets a sticky power-fail status bit, but only while the interrupt enable in the configuration register is set. The block drives four outputs: a level power-fail interrupt, a one-cycle floppy terminal-count pulse, a one-cycle power-off request and a one-cycle system reset request. When the block is reset, the diagnostic, LED and system-control registers keep their contents.

Top module: `aux_sysctl_regs`

## Requirements
- R1: An access is legal only at its region's size: byte (bus_size=0) for configuration, diagnostic, modem, aux1 and aux2; half-word (bus_size=1) for LED; word (bus_size=2) for system-control. A write of any other size changes nothing, and a read of any other size returns 0.
- R2: For LED and system-control, a nonzero bus_addr makes reads return 0 and makes writes change nothing.
- R3: irq_pwrfail is high exactly when the stored power-fail status (aux2 bit 5) and the enable (configuration bit 3) are both 1. It follows a configuration or aux2 write in the cycle after that write's clock edge.
- R4: When the synchronized power-failing level changes, the power-fail status is loaded with that level ANDed with the enable bit. The change takes effect at the third rising edge after the input changes. While the input holds steady, the status does not change.
- R5: An aux2 write takes only bit 0 (power off) and bit 1 (clear) from the data. Bit 1 clears the power-fail status and is never stored. An aux2 read shows only bit 5 (status) and bit 0 (power off). If a power-fail input change falls in the same cycle as the write, the input change takes precedence.
- R6: pwroff_req pulses for exactly one cycle after a legal aux2 write with bit 0 set.
- R7: A legal aux1 write with bit 1 set gives tc_pulse high for exactly one cycle. The aux1 register stores the written byte with bit 1 forced to 0.
- R8: A legal word write to system-control at offset 0 with bit 0 set loads the register with 0x02 and gives sysreset_req high for one cycle. A write with bit 0 clear has no effect.
- R9: Reset (rst_n low at a rising edge) clears configuration, aux1, aux2, modem control, the power-fail status and all pulses. Diagnostic, LED and system-control keep their values.
- R10: The configuration, diagnostic and modem-control registers store the written byte unchanged, and the LED register stores the written half-word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_cfg | input | 1 | Selects the configuration register |
| sel_diag | input | 1 | Selects the diagnostic register |
| sel_mdm | input | 1 | Selects the modem-control register |
| sel_aux1 | input | 1 | Selects the misc-functions register |
| sel_aux2 | input | 1 | Selects the power-control register |
| sel_led | input | 1 | Selects the LED register |
| sel_sys | input | 1 | Selects the system-control register |
| bus_wr | input | 1 | Write strobe for the selected region |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_addr | input | 2 | Byte offset inside the region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected region |
| pf_in | input | 1 | Asynchronous power-failing indication |
| irq_pwrfail | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count pulse |
| pwroff_req | output | 1 | Power-off request pulse |
| sysreset_req | output | 1 | System reset request pulse |

## Verification
A register write appears on the combinational read data, and on irq_pwrfail, in the cycle after the clock edge that samples the write. The three pulse outputs are high only for that same cycle after the edge. A change on pf_in reaches the status bit only at the third rising edge, because it passes two synchronizer stages and one change detector. The bench model uses the same three-edge history for pf_in. Every falling edge compares all four outputs with the model, so a result that arrives one cycle early or late shows up as a mismatch.

// File: rtl/aux_sysctl_pkg.sv
// Package: shared access-size encoding and bit positions for the
// auxiliary I/O and system-control register block.
package aux_sysctl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // One flag per register region
    typedef struct packed {
        logic cfg;
        logic diag;
        logic mdm;
        logic aux1;
        logic aux2;
        logic led;
        logic sys;
    } region_t;

    localparam int          CFG_PFEN_BIT   = 3;
    localparam int          AUX2_PFST_BIT  = 5;
    localparam int          AUX2_OFF_BIT   = 0;
    localparam int          AUX2_CLR_BIT   = 1;
    localparam int          AUX1_TC_BIT    = 1;
    localparam int          SYS_RST_BIT    = 0;
    localparam logic [7:0]  SYS_RST_STATUS = 8'h02;

endpackage

// File: rtl/aux_pf_sync.sv
// Module: aux_pf_sync
// Synchronizes the asynchronous power-failing input through STAGES flops
// and flags each cycle where the synchronized level differs from the
// level one cycle earlier.
// Assumes: STAGES >= 1; synchronous active-low reset clears the chain.
module aux_pf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic changed
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the input through the synchronizer and keep the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            prev_q <= chain_q[STAGES-1];
        end
    end

    // Expose the synchronized level and its change flag
    always_comb begin
        level   = chain_q[STAGES-1];
        changed = chain_q[STAGES-1] ^ prev_q;
    end

endmodule

// File: rtl/aux_bus_decode.sv
// Module: aux_bus_decode
// Works out, for each region, whether the current access is legal: the
// region must be selected, the size must match, and for the half-word and
// word regions the offset must be zero.
// Assumes: at most one select is high in any cycle.
module aux_bus_decode
    import aux_sysctl_pkg::*;
#(
    parameter int OFFS_W = 2
) (
    input  region_t           sel,
    input  logic [1:0]        size,
    input  logic [OFFS_W-1:0] offs,
    output region_t           legal
);

    logic offs_zero;

    // Qualify every select with its size and offset rule
    always_comb begin
        offs_zero  = (offs == '0);
        legal.cfg  = sel.cfg  && (size == SZ_BYTE);
        legal.diag = sel.diag && (size == SZ_BYTE);
        legal.mdm  = sel.mdm  && (size == SZ_BYTE);
        legal.aux1 = sel.aux1 && (size == SZ_BYTE);
        legal.aux2 = sel.aux2 && (size == SZ_BYTE);
        legal.led  = sel.led  && (size == SZ_HALF) && offs_zero;
        legal.sys  = sel.sys  && (size == SZ_WORD) && offs_zero;
    end

endmodule

// File: rtl/aux_pwr_ctrl.sv
// Module: aux_pwr_ctrl
// Holds the configuration register and the power-control register: the
// sticky power-fail status, its write-one clear, the stored power-off bit,
// the power-off request pulse and the power-fail interrupt.
// Assumes: pf_level/pf_changed come from a synchronizer; an input change
// takes precedence over a clear written in the same cycle.
module aux_pwr_ctrl
    import aux_sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       aux2_wr,
    input  logic [7:0] wdata,
    input  logic       pf_level,
    input  logic       pf_changed,
    output logic [7:0] cfg_q,
    output logic [7:0] aux2_q,
    output logic       irq,
    output logic       pwroff_req
);

    logic pf_st_q;
    logic off_q;
    logic off_req_q;

    // Configuration byte, power-off bit and power-off request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            off_q     <= 1'b0;
            off_req_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                cfg_q <= wdata;
            end
            if (aux2_wr) begin
                off_q <= wdata[AUX2_OFF_BIT];
            end
            off_req_q <= aux2_wr && wdata[AUX2_OFF_BIT];
        end
    end

    // Sticky power-fail status: loaded on input change, cleared by write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_st_q <= 1'b0;
        end else if (pf_changed) begin
            pf_st_q <= pf_level && cfg_q[CFG_PFEN_BIT];
        end else if (aux2_wr && wdata[AUX2_CLR_BIT]) begin
            pf_st_q <= 1'b0;
        end
    end

    // Assemble the aux2 read view and the interrupt
    always_comb begin
        aux2_q                = '0;
        aux2_q[AUX2_PFST_BIT] = pf_st_q;
        aux2_q[AUX2_OFF_BIT]  = off_q;
        irq                   = pf_st_q && cfg_q[CFG_PFEN_BIT];
        pwroff_req            = off_req_q;
    end

endmodule

// File: rtl/aux_sysctl_regs.sv
// Module: aux_sysctl_regs (top)
// Register block for auxiliary I/O and system control. Every region has its
// own select. Write data is captured at the rising edge, and read data is
// combinational from the selected region. The diagnostic, LED and
// system-control registers are deliberately left out of the reset.
// Assumes: selects are one-hot or idle; bus_size is 0 byte, 1 half, 2 word.
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int OFFS_W    = 2,
    parameter int PF_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_cfg,
    input  logic              sel_diag,
    input  logic              sel_mdm,
    input  logic              sel_aux1,
    input  logic              sel_aux2,
    input  logic              sel_led,
    input  logic              sel_sys,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pf_in,
    output logic              irq_pwrfail,
    output logic              tc_pulse,
    output logic              pwroff_req,
    output logic              sysreset_req
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    region_t           sel;
    region_t           legal;
    region_t           wr;
    logic [BYTE_W-1:0] cfg_q;
    logic [BYTE_W-1:0] aux2_q;
    logic [BYTE_W-1:0] diag_q;
    logic [BYTE_W-1:0] mdm_q;
    logic [BYTE_W-1:0] aux1_q;
    logic [HALF_W-1:0] led_q;
    logic [BYTE_W-1:0] sys_q;
    logic              tc_q;
    logic              rst_req_q;
    logic              pf_level;
    logic              pf_changed;
    logic              unused_wdata_hi;

    // Gather the selects and form the per-region write strobes
    always_comb begin
        sel.cfg  = sel_cfg;
        sel.diag = sel_diag;
        sel.mdm  = sel_mdm;
        sel.aux1 = sel_aux1;
        sel.aux2 = sel_aux2;
        sel.led  = sel_led;
        sel.sys  = sel_sys;
        wr       = bus_wr ? legal : '0;
    end

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:HALF_W];

    aux_bus_decode #(.OFFS_W(OFFS_W)) dec_i (
        .sel   (sel),
        .size  (bus_size),
        .offs  (bus_addr),
        .legal (legal)
    );

    aux_pf_sync #(.STAGES(PF_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pf_in),
        .level    (pf_level),
        .changed  (pf_changed)
    );

    aux_pwr_ctrl pwr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (wr.cfg),
        .aux2_wr    (wr.aux2),
        .wdata      (bus_wdata[BYTE_W-1:0]),
        .pf_level   (pf_level),
        .pf_changed (pf_changed),
        .cfg_q      (cfg_q),
        .aux2_q     (aux2_q),
        .irq        (irq_pwrfail),
        .pwroff_req (pwroff_req)
    );

    // Reset-cleared byte registers and the two request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdm_q     <= '0;
            aux1_q    <= '0;
            tc_q      <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (wr.mdm) begin
                mdm_q <= bus_wdata[BYTE_W-1:0];
            end
            if (wr.aux1) begin
                aux1_q              <= bus_wdata[BYTE_W-1:0];
                aux1_q[AUX1_TC_BIT] <= 1'b0;
            end
            tc_q      <= wr.aux1 && bus_wdata[AUX1_TC_BIT];
            rst_req_q <= wr.sys && bus_wdata[SYS_RST_BIT];
        end
    end

    // Registers that keep their contents through reset
    always_ff @(posedge clk) begin
        if (wr.diag) begin
            diag_q <= bus_wdata[BYTE_W-1:0];
        end
        if (wr.led) begin
            led_q <= bus_wdata[HALF_W-1:0];
        end
        if (wr.sys && bus_wdata[SYS_RST_BIT]) begin
            sys_q <= SYS_RST_STATUS;
        end
    end

    // Read data from the region whose access is legal, zero otherwise
    always_comb begin
        bus_rdata = '0;
        if (legal.cfg)  bus_rdata[BYTE_W-1:0] = cfg_q;
        if (legal.diag) bus_rdata[BYTE_W-1:0] = diag_q;
        if (legal.mdm)  bus_rdata[BYTE_W-1:0] = mdm_q;
        if (legal.aux1) bus_rdata[BYTE_W-1:0] = aux1_q;
        if (legal.aux2) bus_rdata[BYTE_W-1:0] = aux2_q;
        if (legal.led)  bus_rdata[HALF_W-1:0] = led_q;
        if (legal.sys)  bus_rdata[BYTE_W-1:0] = sys_q;
        tc_pulse     = tc_q;
        sysreset_req = rst_req_q;
    end

endmodule

// File: rtl/aux_sysctl_chk.sv
// Module: aux_sysctl_chk
// Assertion checker bound to aux_sysctl_regs. It watches only the ports and
// relates the output pulses and the read data to the bus accesses that
// cause them.
// Assumes: bus_size 0 byte, 1 half, 2 word.
module aux_sysctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_cfg,
    input logic        sel_diag,
    input logic        sel_mdm,
    input logic        sel_aux1,
    input logic        sel_aux2,
    input logic        sel_led,
    input logic        sel_sys,
    input logic        bus_wr,
    input logic [1:0]  bus_size,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        tc_pulse,
    input logic        pwroff_req,
    input logic        sysreset_req
);

    // bus rule: one region at a time
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_cfg, sel_diag, sel_mdm, sel_aux1, sel_aux2, sel_led, sel_sys}));

    // R7
    tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(bus_wr && sel_aux1 && bus_size == 2'd0 && bus_wdata[1]));

    // R7
    aux1_tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_aux1 && bus_size == 2'd0) |-> !bus_rdata[1]);

    // R6
    pwroff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwroff_req |-> $past(bus_wr && sel_aux2 && bus_size == 2'd0 && bus_wdata[0]));

    // R8
    sysrst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sysreset_req |-> $past(bus_wr && sel_sys && bus_size == 2'd2 &&
                               bus_addr == 2'd0 && bus_wdata[0]));

    // R5
    aux2_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_aux2 && bus_size == 2'd0) |-> ((bus_rdata & 32'hFFFF_FFDE) == 32'h0));

    // R1
    led_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_led && bus_size != 2'd1) |-> (bus_rdata == 32'h0));

    // R2
    led_offs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_led && bus_addr != 2'd0) |-> (bus_rdata == 32'h0));

    // R2
    sys_offs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sys && bus_addr != 2'd0) |-> (bus_rdata == 32'h0));

endmodule

bind aux_sysctl_regs aux_sysctl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_cfg      (sel_cfg),
    .sel_diag     (sel_diag),
    .sel_mdm      (sel_mdm),
    .sel_aux1     (sel_aux1),
    .sel_aux2     (sel_aux2),
    .sel_led      (sel_led),
    .sel_sys      (sel_sys),
    .bus_wr       (bus_wr),
    .bus_size     (bus_size),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .tc_pulse     (tc_pulse),
    .pwroff_req   (pwroff_req),
    .sysreset_req (sysreset_req)
);

// File: tb/aux_sysctl_regs_tb.sv
`timescale 1ns/1ps
// Bench for aux_sysctl_regs: a behavioural reference model advances at each
// rising edge, and every falling edge compares the outputs with it.
module aux_sysctl_regs_tb_top;

    localparam int RG_CFG = 0, RG_DIAG = 1, RG_MDM = 2, RG_AUX1 = 3;
    localparam int RG_AUX2 = 4, RG_LED = 5, RG_SYS = 6, RG_NONE = -1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_cfg = 0, sel_diag = 0, sel_mdm = 0, sel_aux1 = 0;
    logic        sel_aux2 = 0, sel_led = 0, sel_sys = 0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        pf_in = 1'b0;
    logic        irq_pwrfail, tc_pulse, pwroff_req, sysreset_req;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_cfg = 0, m_diag = 0, m_mdm = 0, m_aux1 = 0, m_led = 0, m_sys = 0;
    bit m_st = 0, m_off = 0, m_tc = 0, m_pwroff = 0, m_rst = 0;
    bit pf_hist[$] = '{1'b0, 1'b0, 1'b0};

    always #4 clk = ~clk;

    aux_sysctl_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .sel_cfg(sel_cfg), .sel_diag(sel_diag), .sel_mdm(sel_mdm),
        .sel_aux1(sel_aux1), .sel_aux2(sel_aux2), .sel_led(sel_led),
        .sel_sys(sel_sys), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pf_in(pf_in), .irq_pwrfail(irq_pwrfail), .tc_pulse(tc_pulse),
        .pwroff_req(pwroff_req), .sysreset_req(sysreset_req)
    );

    // Model step at every rising edge
    always @(posedge clk) begin
        bit ev;
        bit lvl;
        int old_cfg;
        bit byte_ok;
        if (!rst_n) begin
            m_cfg = 0; m_aux1 = 0; m_mdm = 0; m_st = 0; m_off = 0;
            m_tc = 0; m_pwroff = 0; m_rst = 0;
            pf_hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            old_cfg = m_cfg;
            lvl     = pf_hist[1];
            ev      = (pf_hist[1] != pf_hist[2]);
            byte_ok = bus_wr && (bus_size == 2'd0);
            m_tc     = byte_ok && sel_aux1 && bus_wdata[1];
            m_pwroff = byte_ok && sel_aux2 && bus_wdata[0];
            m_rst    = bus_wr && sel_sys && bus_size == 2'd2 && bus_addr == 0 && bus_wdata[0];
            if (byte_ok && sel_cfg)  m_cfg  = int'(bus_wdata[7:0]);
            if (byte_ok && sel_diag) m_diag = int'(bus_wdata[7:0]);
            if (byte_ok && sel_mdm)  m_mdm  = int'(bus_wdata[7:0]);
            if (byte_ok && sel_aux1) m_aux1 = int'(bus_wdata[7:0]) & 8'hFD;
            if (bus_wr && sel_led && bus_size == 2'd1 && bus_addr == 0)
                m_led = int'(bus_wdata[15:0]);
            if (m_rst) m_sys = 2;
            if (byte_ok && sel_aux2) begin
                m_off = bus_wdata[0];
                if (bus_wdata[1]) m_st = 1'b0;
            end
            if (ev) m_st = lvl && old_cfg[3];
            pf_hist.push_front(pf_in);
            void'(pf_hist.pop_back());
        end
    end

    function automatic int model_read(int rg, int sz, int ad);
        case (rg)
            RG_CFG:  return (sz == 0) ? m_cfg : 0;
            RG_DIAG: return (sz == 0) ? m_diag : 0;
            RG_MDM:  return (sz == 0) ? m_mdm : 0;
            RG_AUX1: return (sz == 0) ? m_aux1 : 0;
            RG_AUX2: return (sz == 0) ? ((m_st ? 32 : 0) + (m_off ? 1 : 0)) : 0;
            RG_LED:  return (sz == 1 && ad == 0) ? m_led : 0;
            RG_SYS:  return (sz == 2 && ad == 0) ? m_sys : 0;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_sel(int rg);
        sel_cfg  = (rg == RG_CFG);
        sel_diag = (rg == RG_DIAG);
        sel_mdm  = (rg == RG_MDM);
        sel_aux1 = (rg == RG_AUX1);
        sel_aux2 = (rg == RG_AUX2);
        sel_led  = (rg == RG_LED);
        sel_sys  = (rg == RG_SYS);
    endtask

    task automatic wr(int rg, int sz, int ad, int d);
        @(negedge clk);
        drive_sel(rg);
        bus_size = 2'(sz); bus_addr = 2'(ad); bus_wdata = 32'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        drive_sel(RG_NONE);
    endtask

    // Read compared to the model and, when exp >= 0, to a fixed value too
    task automatic rd(string req, int rg, int sz, int ad, int exp = -1);
        @(negedge clk);
        drive_sel(rg);
        bus_size = 2'(sz); bus_addr = 2'(ad);
        #1;
        chk(req, int'(bus_rdata), model_read(rg, sz, ad));
        if (exp >= 0) chk(req, int'(bus_rdata), exp);
        drive_sel(RG_NONE);
        bus_size = 2'd0; bus_addr = 2'd0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Per-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R3 irq_pwrfail", int'(irq_pwrfail), int'(m_st && m_cfg[3]));
            chk("R7 tc_pulse", int'(tc_pulse), int'(m_tc));
            chk("R6 pwroff_req", int'(pwroff_req), int'(m_pwroff));
            chk("R8 sysreset_req", int'(sysreset_req), int'(m_rst));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R9 reset state
        rd("R9 cfg after reset", RG_CFG, 0, 0, 0);
        rd("R9 aux1 after reset", RG_AUX1, 0, 0, 0);
        rd("R9 aux2 after reset", RG_AUX2, 0, 0, 0);
        rd("R9 mdm after reset", RG_MDM, 0, 0, 0);
        // R10 plain byte storage
        wr(RG_CFG, 0, 0, 'h5A);   rd("R10 cfg", RG_CFG, 0, 0, 'h5A);
        wr(RG_DIAG, 0, 0, 'hC3);  rd("R10 diag", RG_DIAG, 0, 0, 'hC3);
        wr(RG_MDM, 0, 0, 'h7E);   rd("R10 mdm", RG_MDM, 0, 0, 'h7E);
        wr(RG_CFG, 0, 0, 'h00);
        // R7 terminal count
        wr(RG_AUX1, 0, 0, 'hFF);  rd("R7 aux1 tc bit clear", RG_AUX1, 0, 0, 'hFD);
        wr(RG_AUX1, 0, 0, 'h40);  rd("R7 aux1 no tc", RG_AUX1, 0, 0, 'h40);
        // R10, R2, R1 LED
        wr(RG_LED, 1, 0, 'hBEEF); rd("R10 led", RG_LED, 1, 0, 'hBEEF);
        wr(RG_LED, 1, 2, 'h1111); rd("R2 led offset write ignored", RG_LED, 1, 0, 'hBEEF);
        rd("R2 led offset read zero", RG_LED, 1, 2, 0);
        wr(RG_LED, 0, 0, 'h22);   rd("R1 led byte write ignored", RG_LED, 1, 0, 'hBEEF);
        rd("R1 led word read zero", RG_LED, 2, 0, 0);
        // R8 system control
        wr(RG_SYS, 2, 0, 'h1);    rd("R8 sys reset status", RG_SYS, 2, 0, 2);
        wr(RG_SYS, 2, 0, 'hFFFFFFFE); rd("R8 bit0 clear no effect", RG_SYS, 2, 0, 2);
        wr(RG_SYS, 2, 1, 'h1);    rd("R2 sys offset read zero", RG_SYS, 2, 1, 0);
        wr(RG_SYS, 0, 0, 'h1);
        // R1 byte regions
        wr(RG_MDM, 1, 0, 'h99);   rd("R1 mdm half write ignored", RG_MDM, 0, 0, 'h7E);
        rd("R1 mdm word read zero", RG_MDM, 2, 0, 0);
        wr(RG_AUX1, 2, 0, 'h02);  rd("R1 aux1 word write no tc", RG_AUX1, 0, 0, 'h40);
        // R4, R3 power fail
        wr(RG_CFG, 0, 0, 'h08);
        @(negedge clk) pf_in = 1'b1;
        idle(5);
        chk("R4 irq after input", int'(irq_pwrfail), 1);
        rd("R4 status set", RG_AUX2, 0, 0, 'h20);
        wr(RG_CFG, 0, 0, 'h00);
        chk("R3 irq masked", int'(irq_pwrfail), 0);
        rd("R3 status sticky", RG_AUX2, 0, 0, 'h20);
        wr(RG_CFG, 0, 0, 'h08);
        chk("R3 irq unmasked", int'(irq_pwrfail), 1);
        wr(RG_AUX2, 0, 0, 'h02);  rd("R5 clear status", RG_AUX2, 0, 0, 0);
        chk("R5 irq cleared", int'(irq_pwrfail), 0);
        @(negedge clk) pf_in = 1'b0;
        idle(4);
        wr(RG_CFG, 0, 0, 'h00);
        @(negedge clk) pf_in = 1'b1;
        idle(5);
        rd("R4 disabled no set", RG_AUX2, 0, 0, 0);
        wr(RG_CFG, 0, 0, 'h08);
        idle(4);
        rd("R4 steady input no set", RG_AUX2, 0, 0, 0);
        @(negedge clk) pf_in = 1'b0;
        idle(4);
        @(negedge clk) pf_in = 1'b1;
        idle(5);
        rd("R4 set on new change", RG_AUX2, 0, 0, 'h20);
        // R5, R6 power control writes
        wr(RG_AUX2, 0, 0, 'h01);  rd("R6 power off stored", RG_AUX2, 0, 0, 'h21);
        wr(RG_AUX2, 0, 0, 'hFC);  rd("R5 other bits ignored", RG_AUX2, 0, 0, 'h20);
        wr(RG_AUX2, 0, 0, 'h03);  rd("R5 clear keeps off bit", RG_AUX2, 0, 0, 'h01);
        // R9 retention across reset
        wr(RG_DIAG, 0, 0, 'h3C);
        wr(RG_LED, 1, 0, 'h55AA);
        wr(RG_MDM, 0, 0, 'h11);
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd("R9 diag kept", RG_DIAG, 0, 0, 'h3C);
        rd("R9 led kept", RG_LED, 1, 0, 'h55AA);
        rd("R9 sys kept", RG_SYS, 2, 0, 2);
        rd("R9 cfg cleared", RG_CFG, 0, 0, 0);
        rd("R9 mdm cleared", RG_MDM, 0, 0, 0);
        rd("R9 aux2 cleared", RG_AUX2, 0, 0, 0);
        chk("R9 irq low", int'(irq_pwrfail), 0);
        idle(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule